// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block converts a pixel coordinate inside a two-dimensional tiled container into a 32-bit address in tiled address space. The caller supplies a pixel format code, a 3-bit view code and the X and Y coordinates. The block returns three things: the address, a flag that says whether the coordinate was in range, and the line stride for the selected view.

Rotation and mirroring cost no arithmetic. Each is a bit operation on the coordinate:

- A coordinate is mirrored by XOR with its all-ones mask.
- Transposition swaps which coordinate takes the upper bits of the packed value.

The number of coordinate bits depends on the format. Wider pixels give up low coordinate bits, and the packed value is then shifted left to make up for them. The format and view codes travel in the top bits of the address, so that the address decoder downstream can recover them.

A parameter selects the output path. It is either purely combinational or registered with one cycle of latency. The default is registered.

Top module: `tiled_addr_gen`

## Requirements
- R1: Address bits [28:27] hold the format code. The codes are 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for page mode.
- R2: Address bits [31:29] hold the view code unchanged. In the view code, bit 2 is transpose, bit 1 is Y mirror and bit 0 is X mirror.
- R3: Each format drops some X and Y coordinate bits, written here as (X, Y):
  - 8-bit drops (0,0).
  - 16-bit drops (0,1).
  - 32-bit drops (1,1).
  - Page mode drops (6,6), the slot width and height bits.
  - The X field is 14 bits minus the X drop. The Y field is 13 bits minus the Y drop.
- R4: If X or Y is above the all-ones mask of its field, the address is 0 and valid_o is 0. Otherwise valid_o is 1.
- R5: When X mirror is set, X is XORed with its mask before packing. When Y mirror is set, Y is XORed with its mask before packing.
- R6: The packed value depends on transpose:
  - With transpose set, it is (X << Ybits) + Y.
  - With transpose clear, it is (Y << Xbits) + X.
- R7: The packed value is shifted left by the sum of the X and Y drop counts and placed in address bits [26:0]. The low bits freed by the shift are therefore zero.
- R8: The stride depends on transpose:
  - With transpose set, it is 1 << (13 + X drop).
  - With transpose clear, it is 1 << (14 + Y drop).
  - The stride is driven even when the coordinate is out of range.
- R9: In the default registered mode, outputs follow inputs after one rising clock edge. While rst_ni is low, addr_o, valid_o and stride_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used in registered mode |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 2 | Pixel format code |
| view_i | input | 3 | View code: transpose, Y mirror, X mirror |
| x_i | input | 16 | X pixel coordinate |
| y_i | input | 16 | Y pixel coordinate |
| addr_o | output | 32 | Tiled-space address |
| valid_o | output | 1 | Coordinate in range |
| stride_o | output | 32 | Line stride for the view |

## Verification
A wrong drop count or mask shows up in the low address field one cycle after the request. It appears either as a field shifted by one bit or as a mirrored coordinate that lands on the wrong edge. A corner vector, such as the all-ones coordinate or the origin under each mirror, exposes it at once. A wrong range check shows a nonzero address with valid_o low, or a zero address with valid_o high, on the first out-of-range request. A wrong transpose select shows as a swapped field order and as a stride taken from the other dimension, in the same cycle.

// File: rtl/tiled_addr_pkg.sv
package tiled_addr_pkg;
  typedef enum logic [1:0] {
    FMT_8B   = 2'd0,
    FMT_16B  = 2'd1,
    FMT_32B  = 2'd2,
    FMT_PAGE = 2'd3
  } fmt_e;

  localparam int VIEW_W = 3;
  localparam int FMT_W  = 2;
  localparam int SKIP_W = 5;

  // view bit roles
  localparam int V_XINV = 0;
  localparam int V_YINV = 1;
  localparam int V_SWAP = 2;

  function automatic logic [SKIP_W-1:0] skip_x(fmt_e f, int sw);
    case (f)
      FMT_32B:  return SKIP_W'(1);
      FMT_PAGE: return SKIP_W'(sw);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [SKIP_W-1:0] skip_y(fmt_e f, int sh);
    case (f)
      FMT_16B, FMT_32B: return SKIP_W'(1);
      FMT_PAGE:         return SKIP_W'(sh);
      default:          return '0;
    endcase
  endfunction
endpackage

// File: rtl/tiled_fmt_geom.sv
module tiled_fmt_geom
  import tiled_addr_pkg::*;
#(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int COORD_W = 16
) (
  input  fmt_e                fmt_i,
  output logic [SKIP_W-1:0]   xu_o,
  output logic [SKIP_W-1:0]   yu_o,
  output logic [SKIP_W-1:0]   xbits_o,
  output logic [SKIP_W-1:0]   ybits_o,
  output logic [COORD_W-1:0]  x_mask_o,
  output logic [COORD_W-1:0]  y_mask_o
);
  localparam logic [SKIP_W-1:0] CW = SKIP_W'(CW_BITS);
  localparam logic [SKIP_W-1:0] CH = SKIP_W'(CH_BITS);

  always_comb begin
    xu_o     = skip_x(fmt_i, SW_BITS);
    yu_o     = skip_y(fmt_i, SH_BITS);
    xbits_o  = CW - xu_o;
    ybits_o  = CH - yu_o;
    x_mask_o = COORD_W'((33'd1 << xbits_o) - 33'd1);
    y_mask_o = COORD_W'((33'd1 << ybits_o) - 33'd1);
  end
endmodule

// File: rtl/tiled_coord_xform.sv
module tiled_coord_xform
  import tiled_addr_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PK_W    = 27
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [VIEW_W-1:0]  view_i,
  input  logic [COORD_W-1:0] x_mask_i,
  input  logic [COORD_W-1:0] y_mask_i,
  input  logic [SKIP_W-1:0]  xbits_i,
  input  logic [SKIP_W-1:0]  ybits_i,
  output logic               in_range_o,
  output logic [PK_W-1:0]    pk_o
);
  logic [COORD_W-1:0] xm, ym;

  always_comb begin
    in_range_o = (x_i <= x_mask_i) && (y_i <= y_mask_i);
    xm = view_i[V_XINV] ? (x_i ^ x_mask_i) : x_i;
    ym = view_i[V_YINV] ? (y_i ^ y_mask_i) : y_i;
    if (view_i[V_SWAP])
      pk_o = (PK_W'(xm) << ybits_i) + PK_W'(ym);
    else
      pk_o = (PK_W'(ym) << xbits_i) + PK_W'(xm);
  end
endmodule

// File: rtl/tiled_addr_pack.sv
module tiled_addr_pack
  import tiled_addr_pkg::*;
#(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int ADDR_W  = 32,
  parameter int PK_W    = 27
) (
  input  logic [PK_W-1:0]   pk_i,
  input  logic              in_range_i,
  input  logic [SKIP_W-1:0] xu_i,
  input  logic [SKIP_W-1:0] yu_i,
  input  fmt_e              fmt_i,
  input  logic [VIEW_W-1:0] view_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] stride_o
);
  localparam int LOW_W = ADDR_W - VIEW_W - FMT_W;
  localparam int EXP_W = $clog2(ADDR_W) + 1;

  logic [ADDR_W-1:0] body;
  logic [EXP_W-1:0]  sexp;

  always_comb begin
    body   = ADDR_W'(pk_i) << (xu_i + yu_i);
    addr_o = in_range_i ? {view_i, fmt_i, body[LOW_W-1:0]} : '0;
    sexp   = view_i[V_SWAP] ? EXP_W'(CH_BITS + int'(xu_i))
                            : EXP_W'(CW_BITS + int'(yu_i));
    stride_o = ADDR_W'(1) << sexp;
  end
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen
  import tiled_addr_pkg::*;
#(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter int COORD_W = 16,
  parameter int ADDR_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic [2:0]        view_i,
  input  logic [15:0]       x_i,
  input  logic [15:0]       y_i,
  output logic [31:0]       addr_o,
  output logic              valid_o,
  output logic [31:0]       stride_o
);
  localparam int PK_W = CW_BITS + CH_BITS;

  fmt_e                fmt;
  logic [SKIP_W-1:0]   xu, yu, xbits, ybits;
  logic [COORD_W-1:0]  x_mask, y_mask, xc, yc;
  logic                in_range;
  logic [PK_W-1:0]     pk;
  logic [ADDR_W-1:0]   addr_d, stride_d;

  assign fmt = fmt_e'(fmt_i);
  assign xc  = COORD_W'(x_i);
  assign yc  = COORD_W'(y_i);

  tiled_fmt_geom #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .SW_BITS(SW_BITS),
    .SH_BITS(SH_BITS), .COORD_W(COORD_W)
  ) u_geom (
    .fmt_i(fmt), .xu_o(xu), .yu_o(yu), .xbits_o(xbits), .ybits_o(ybits),
    .x_mask_o(x_mask), .y_mask_o(y_mask)
  );

  tiled_coord_xform #(.COORD_W(COORD_W), .PK_W(PK_W)) u_xform (
    .x_i(xc), .y_i(yc), .view_i(view_i), .x_mask_i(x_mask), .y_mask_i(y_mask),
    .xbits_i(xbits), .ybits_i(ybits), .in_range_o(in_range), .pk_o(pk)
  );

  tiled_addr_pack #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .ADDR_W(ADDR_W), .PK_W(PK_W)
  ) u_pack (
    .pk_i(pk), .in_range_i(in_range), .xu_i(xu), .yu_i(yu), .fmt_i(fmt),
    .view_i(view_i), .addr_o(addr_d), .stride_o(stride_d)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_o   <= '0;
          valid_o  <= 1'b0;
          stride_o <= '0;
        end else begin
          addr_o   <= 32'(addr_d);
          valid_o  <= in_range;
          stride_o <= 32'(stride_d);
        end
      end
    end else begin : g_comb
      assign addr_o   = 32'(addr_d);
      assign valid_o  = in_range;
      assign stride_o = 32'(stride_d);
    end
  endgenerate
endmodule

// File: rtl/tiled_addr_gen_chk.sv
module tiled_addr_gen_chk
  import tiled_addr_pkg::*;
#(
  parameter int SW_BITS = 6,
  parameter int SH_BITS = 6,
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  fmt_i,
  input logic [2:0]  view_i,
  input logic [31:0] addr_o,
  input logic        valid_o,
  input logic [31:0] stride_o
);
  generate
    if (REG_OUT) begin : g_chk
      logic [1:0]  fmt_q;
      logic [31:0] low_mask;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fmt_q <= 2'd0;
        else         fmt_q <= fmt_i;
      end

      always_comb
        low_mask = (32'd1 << (skip_x(fmt_e'(fmt_q), SW_BITS)
                            + skip_y(fmt_e'(fmt_q), SH_BITS))) - 32'd1;

      a_r4_invalid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> addr_o == 32'd0);
      a_r1_fmt_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> addr_o[28:27] == $past(fmt_i));
      a_r2_view_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> addr_o[31:29] == $past(view_i));
      a_r8_stride_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $countones(stride_o) == 1);
      a_r7_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (addr_o & low_mask) == 32'd0);
    end
  endgenerate
endmodule

bind tiled_addr_gen tiled_addr_gen_chk #(
  .SW_BITS(SW_BITS), .SH_BITS(SH_BITS), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fmt_i(fmt_i), .view_i(view_i),
  .addr_o(addr_o), .valid_o(valid_o), .stride_o(stride_o)
);

// File: tb/tiled_addr_gen_bench.sv
module tiled_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  fmt_i = '0;
  logic [2:0]  view_i = '0;
  logic [15:0] x_i = '0, y_i = '0;
  logic [31:0] addr_o, stride_o;
  logic        valid_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tiled_addr_gen u_tiled_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt_i), .view_i(view_i),
    .x_i(x_i), .y_i(y_i), .addr_o(addr_o), .valid_o(valid_o), .stride_o(stride_o)
  );

  typedef struct packed {
    logic [1:0]  f;
    logic [2:0]  v;
    logic [15:0] x;
    logic [15:0] y;
    logic [31:0] a;
    logic        ok;
    logic [31:0] s;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 16'h0001, 16'h0000, 32'h0000_0001, 1'b1, 32'h0000_4000},
    '{2'd0, 3'd0, 16'h0000, 16'h0001, 32'h0000_4000, 1'b1, 32'h0000_4000},
    '{2'd1, 3'd0, 16'h0003, 16'h0002, 32'h0801_0006, 1'b1, 32'h0000_8000},
    '{2'd2, 3'd0, 16'h0005, 16'h0001, 32'h1000_8014, 1'b1, 32'h0000_8000},
    '{2'd0, 3'd1, 16'h0000, 16'h0000, 32'h2000_3FFF, 1'b1, 32'h0000_4000},
    '{2'd0, 3'd2, 16'h0000, 16'h0000, 32'h47FF_C000, 1'b1, 32'h0000_4000},
    '{2'd0, 3'd4, 16'h0002, 16'h0003, 32'h8000_4003, 1'b1, 32'h0000_2000},
    '{2'd3, 3'd0, 16'h0001, 16'h0001, 32'h1810_1000, 1'b1, 32'h0010_0000},
    '{2'd3, 3'd6, 16'h0000, 16'h0000, 32'hD807_F000, 1'b1, 32'h0008_0000},
    '{2'd0, 3'd0, 16'h3FFF, 16'h1FFF, 32'h07FF_FFFF, 1'b1, 32'h0000_4000},
    '{2'd0, 3'd0, 16'h4000, 16'h0000, 32'h0000_0000, 1'b0, 32'h0000_4000},
    '{2'd1, 3'd0, 16'h0000, 16'h1000, 32'h0000_0000, 1'b0, 32'h0000_8000},
    '{2'd2, 3'd7, 16'h1FFF, 16'h0FFF, 32'hF000_0000, 1'b1, 32'h0000_4000},
    '{2'd3, 3'd0, 16'h0100, 16'h0000, 32'h0000_0000, 1'b0, 32'h0010_0000}
  };

  // Requirement-level model: drops per format, 14/13 container bits
  function automatic void model(input logic [1:0] f, input logic [2:0] v,
                                input logic [15:0] x, input logic [15:0] y,
                                output logic [31:0] a, output logic ok,
                                output logic [31:0] s);
    int dx, dy, nx, ny;
    longint mx, my, xx, yy, pk;
    dx = (f == 2) ? 1 : (f == 3) ? 6 : 0;
    dy = (f == 1 || f == 2) ? 1 : (f == 3) ? 6 : 0;
    nx = 14 - dx; ny = 13 - dy;
    mx = (64'd1 << nx) - 1; my = (64'd1 << ny) - 1;
    xx = x; yy = y;
    ok = (xx <= mx) && (yy <= my);
    if (v[0]) xx = xx ^ mx;
    if (v[1]) yy = yy ^ my;
    pk = v[2] ? ((xx << ny) + yy) : ((yy << nx) + xx);
    pk = pk << (dx + dy);
    a = ok ? {v, f, pk[26:0]} : 32'd0;
    s = v[2] ? (32'd1 << (13 + dx)) : (32'd1 << (14 + dy));
  endfunction

  task automatic check(input string req, input logic [31:0] ea, input logic eok,
                       input logic [31:0] es);
    checks++;
    if (addr_o !== ea || valid_o !== eok || stride_o !== es) begin
      failures++;
      $display("FAIL %s: addr=%h valid=%0b stride=%h expected addr=%h valid=%0b stride=%h",
               req, addr_o, valid_o, stride_o, ea, eok, es);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [2:0] v,
                       input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    fmt_i = f; view_i = v; x_i = x; y_i = y;
    @(negedge clk);  // one posedge between: registered output settled
  endtask

  initial begin
    logic [31:0] ea, es;
    logic eok;
    fmt_i = 2'd2; view_i = 3'd5; x_i = 16'h12; y_i = 16'h34;
    repeat (3) @(negedge clk);
    check("R9 reset", 32'd0, 1'b0, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].f, VECS[i].v, VECS[i].x, VECS[i].y);
      // R1 R2 R3 R4 R5 R6 R7 R8 covered by the table entries
      check($sformatf("R1-8 vec%0d", i), VECS[i].a, VECS[i].ok, VECS[i].s);
    end

    // sweep every format and view (R2 R5 R6)
    for (int f = 0; f < 4; f++)
      for (int v = 0; v < 8; v++) begin
        apply(2'(f), 3'(v), 16'd5, 16'd3);
        model(2'(f), 3'(v), 16'd5, 16'd3, ea, eok, es);
        check("R2 R5 R6 sweep", ea, eok, es);
      end

    // each format just out of range in X and in Y (R3 R4)
    for (int f = 0; f < 4; f++) begin
      logic [15:0] lim_x, lim_y;
      lim_x = (f == 2) ? 16'h2000 : (f == 3) ? 16'h0100 : 16'h4000;
      lim_y = (f == 0) ? 16'h2000 : (f == 3) ? 16'h0080 : 16'h1000;
      apply(2'(f), 3'd3, lim_x, 16'd0);
      model(2'(f), 3'd3, lim_x, 16'd0, ea, eok, es);
      check("R4 x edge", ea, eok, es);
      apply(2'(f), 3'd3, lim_x - 16'd1, lim_y - 16'd1);
      model(2'(f), 3'd3, lim_x - 16'd1, lim_y - 16'd1, ea, eok, es);
      check("R3 max in range", ea, eok, es);
      apply(2'(f), 3'd4, 16'd0, lim_y);
      model(2'(f), 3'd4, 16'd0, lim_y, ea, eok, es);
      check("R4 y edge", ea, eok, es);
    end

    // one-cycle latency: output must not move before the edge (R9)
    apply(2'd0, 3'd0, 16'd1, 16'd0);
    @(negedge clk);
    fmt_i = 2'd3; view_i = 3'd0; x_i = 16'd1; y_i = 16'd1;
    #1;
    check("R9 latency hold", 32'h0000_0001, 1'b1, 32'h0000_4000);
    @(negedge clk);
    check("R9 latency update", 32'h1810_1000, 1'b1, 32'h0010_0000);

    // asynchronous reset clears outputs (R9)
    #1 rst_ni = 1'b0;
    #1 check("R9 async reset", 32'd0, 1'b0, 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule